// File: doc/BRIEF.md
# Vector Element Address Generator

This block produces the memory address of every element of one vector load or store. A single start pulse captures an addressing mode, a base address, a signed stride and a vector length. The block then waits a fixed start-up interval and emits one address per clock on a valid/ready output. Each address carries the number of its element. A one-cycle done pulse follows the acceptance of the final address.

The block has three address rules. Unit stride walks consecutive 8-byte words. Strided mode steps by a signed scalar. Indexed mode adds each offset taken from a streamed index vector to the base, and this rule serves gather loads and scatter stores alike. The caller places the block between the instruction issue logic and the memory access pipe. The memory itself, the data movement and any bank scheduling are outside it.

Top module: `vec_addr_gen`

## Requirements
- R1: With `mode_i` = 0 (unit stride), element i is presented with address `base + 8*i`.
- R2: With `mode_i` = 1 (strided), element i is presented with address `base + i*stride`. `stride_i` is read as signed two's complement, and all address arithmetic wraps modulo 2^32.
- R3: With `mode_i` = 2 (indexed gather), element i is presented with address `base + index[i]`. The block takes index words in order, one per element, through `idx_valid_i`/`idx_ready_o`. `idx_ready_o` is asserted only in the indexed modes.
- R4: With `mode_i` = 3 (indexed scatter), addresses and index consumption follow exactly the R3 rule.
- R5: The block emits exactly `vlen_i` elements, tagged 0 to n-1 in increasing order on `elem_o`. A length above 64 is treated as 64.
- R6: `addr_valid_o` stays low for the 12 clock edges that follow the edge accepting start, counting that edge. In unit or strided mode, the first address is valid right after the 12th following edge.
- R7: In unit or strided mode with `addr_ready_i` held high, the block issues one element per clock with no gaps. The done pulse therefore follows start by exactly 12 + n edges.
- R8: While `addr_valid_o` is high and `addr_ready_i` is low, the address and element number do not change and valid stays high.
- R9: `done_o` is high for exactly the one cycle after the last element is accepted, and never together with `addr_valid_o`. A start with length 0 raises `done_o` in the next cycle and issues no address.
- R10: `busy_o` is high from the accepted start until the last element is accepted. A start pulse seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin one vector access (taken only while idle) |
| mode_i | input | 2 | 0 unit, 1 strided, 2 gather, 3 scatter |
| base_i | input | 32 | Base byte address |
| stride_i | input | 32 | Signed byte stride for strided mode |
| vlen_i | input | 7 | Element count, capped at 64 |
| busy_o | output | 1 | An access is in progress |
| idx_valid_i | input | 1 | Index word available |
| idx_data_i | input | 32 | Index word (byte offset from base) |
| idx_ready_o | output | 1 | Index word is taken at this edge |
| addr_valid_o | output | 1 | Address beat valid |
| addr_ready_i | input | 1 | Consumer accepts the beat |
| addr_o | output | 32 | Element address |
| elem_o | output | 6 | Element number of the beat |
| done_o | output | 1 | One-cycle end-of-access pulse |

## Verification
Unit-stride runs with the consumer always ready fix the exact start-up delay and the gap-free rate. A negative stride under periodic back-pressure separates a signed step from an unsigned one and exposes any movement of a held beat. A stride that crosses 2^32 exercises the wrap rule. Gather and scatter runs, with a gappy index stream and a stalling consumer, show that offsets are paired with the right element no matter when each side stalls. Zero-length, over-length and mid-run start pulses cover the edges of the length and start handling.

// File: rtl/vag_pkg.sv
package vag_pkg;

    localparam int DEF_ADDR_W     = 32;
    localparam int DEF_MAX_VL     = 64;
    localparam int DEF_STARTUP    = 12;
    localparam int DEF_WORD_SHIFT = 3;

    typedef enum logic [1:0] {
        AM_UNIT    = 2'd0,
        AM_STRIDE  = 2'd1,
        AM_GATHER  = 2'd2,
        AM_SCATTER = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WAIT  = 2'd1,
        PH_ISSUE = 2'd2
    } phase_e;

    function automatic logic is_indexed(amode_e m);
        return (m == AM_GATHER) || (m == AM_SCATTER);
    endfunction

endpackage

// File: rtl/vag_ctrl.sv
module vag_ctrl
    import vag_pkg::*;
#(
    parameter int MAX_VL  = DEF_MAX_VL,
    parameter int STARTUP = DEF_STARTUP,
    localparam int VL_W   = $clog2(MAX_VL + 1),
    localparam int ELEM_W = $clog2(MAX_VL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    input  logic [VL_W-1:0]   vlen_i,
    input  logic              can_load_i,
    input  logic              idx_valid_i,
    input  logic              hs_i,
    input  logic [ELEM_W-1:0] hs_elem_i,
    output logic              accept_o,
    output logic              load_o,
    output logic [ELEM_W-1:0] elem_o,
    output logic              idx_ready_o,
    output logic              done_o,
    output logic              busy_o,
    output amode_e            mode_q_o
);

    localparam int CNT_W = $clog2(STARTUP);
    localparam logic [CNT_W-1:0] WAIT_INIT = CNT_W'(STARTUP - 2);
    localparam logic [VL_W-1:0]  CAP       = VL_W'(MAX_VL);

    phase_e            phase_q;
    amode_e            mode_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [VL_W-1:0]   len_q;
    logic [VL_W-1:0]   nxt_q;
    logic              done_q;

    logic [VL_W-1:0]   len_in;
    logic              have_next;
    logic              issue_ok;
    logic              finish;
    logic              idx_mode;

    assign len_in    = (vlen_i > CAP) ? CAP : vlen_i;
    assign accept_o  = start_i && (phase_q == PH_IDLE);
    assign have_next = nxt_q < len_q;
    assign idx_mode  = is_indexed(mode_q);
    assign issue_ok  = (phase_q == PH_ISSUE) && have_next && can_load_i;
    assign idx_ready_o = issue_ok && idx_mode;
    assign load_o    = issue_ok && (!idx_mode || idx_valid_i);
    assign finish    = (phase_q == PH_ISSUE) && hs_i &&
                       ({1'b0, hs_elem_i} == (len_q - VL_W'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            mode_q  <= AM_UNIT;
            cnt_q   <= '0;
            len_q   <= '0;
            nxt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        mode_q <= amode_e'(mode_i);
                        len_q  <= len_in;
                        nxt_q  <= '0;
                        if (len_in == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            phase_q <= PH_WAIT;
                            cnt_q   <= WAIT_INIT;
                        end
                    end
                end
                PH_WAIT: begin
                    if (cnt_q == '0) phase_q <= PH_ISSUE;
                    else             cnt_q   <= cnt_q - CNT_W'(1);
                end
                PH_ISSUE: begin
                    if (load_o) nxt_q <= nxt_q + VL_W'(1);
                    if (finish) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign elem_o   = nxt_q[ELEM_W-1:0];
    assign done_o   = done_q;
    assign busy_o   = (phase_q != PH_IDLE);
    assign mode_q_o = mode_q;

    // length never exceeds the cap
    assert_len_cap_R5: assert property (@(posedge clk) disable iff (rst)
        len_q <= CAP);

    // element counter stays within the captured length
    assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
        nxt_q <= len_q);

    // index words are only taken in the indexed modes
    assert_idx_mode_only_R3: assert property (@(posedge clk) disable iff (rst)
        idx_ready_o |-> (mode_q == AM_GATHER || mode_q == AM_SCATTER));

    // a start pulse while busy leaves the captured job alone
    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> ($stable(len_q) && $stable(mode_q)));

endmodule

// File: rtl/vag_addr.sv
module vag_addr
    import vag_pkg::*;
#(
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int WORD_SHIFT = DEF_WORD_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_i,
    input  logic [1:0]        mode_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  amode_e            mode_q_i,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] idx_data_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam logic [ADDR_W-1:0] UNIT_STEP = ADDR_W'(1) << WORD_SHIFT;

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] step_q;
    logic [ADDR_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            step_q <= '0;
            run_q  <= '0;
        end else if (accept_i) begin
            base_q <= base_i;
            run_q  <= base_i;
            step_q <= (amode_e'(mode_i) == AM_UNIT) ? UNIT_STEP : stride_i;
        end else if (load_i && !is_indexed(mode_q_i)) begin
            run_q <= run_q + step_q;
        end
    end

    assign addr_o = is_indexed(mode_q_i) ? (base_q + idx_data_i) : run_q;

endmodule

// File: rtl/vag_out.sv
module vag_out #(
    parameter int ADDR_W = 32,
    parameter int ELEM_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ELEM_W-1:0] elem_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ELEM_W-1:0] elem_o,
    output logic              can_load_o,
    output logic              hs_o
);

    logic              valid_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ELEM_W-1:0] elem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
            elem_q  <= '0;
        end else if (load_i) begin
            valid_q <= 1'b1;
            addr_q  <= addr_i;
            elem_q  <= elem_i;
        end else if (ready_i) begin
            valid_q <= 1'b0;
        end
    end

    assign valid_o    = valid_q;
    assign addr_o     = addr_q;
    assign elem_o     = elem_q;
    assign can_load_o = !valid_q || ready_i;
    assign hs_o       = valid_q && ready_i;

    // a stalled beat is held unchanged
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !ready_i) |=> (valid_q && $stable(addr_q) && $stable(elem_q)));

endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
    import vag_pkg::*;
#(
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int MAX_VL     = DEF_MAX_VL,
    parameter int STARTUP    = DEF_STARTUP,
    parameter int WORD_SHIFT = DEF_WORD_SHIFT,
    localparam int VL_W      = $clog2(MAX_VL + 1),
    localparam int ELEM_W    = $clog2(MAX_VL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  logic [VL_W-1:0]   vlen_i,
    output logic              busy_o,
    input  logic              idx_valid_i,
    input  logic [ADDR_W-1:0] idx_data_i,
    output logic              idx_ready_o,
    output logic              addr_valid_o,
    input  logic              addr_ready_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ELEM_W-1:0] elem_o,
    output logic              done_o
);

    localparam int AGE_W = $clog2(STARTUP + 1);

    logic              accept;
    logic              load;
    logic [ELEM_W-1:0] gen_elem;
    logic [ADDR_W-1:0] gen_addr;
    logic              can_load;
    logic              hs;
    amode_e            mode_q;

    vag_ctrl #(.MAX_VL(MAX_VL), .STARTUP(STARTUP)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .mode_i     (mode_i),
        .vlen_i     (vlen_i),
        .can_load_i (can_load),
        .idx_valid_i(idx_valid_i),
        .hs_i       (hs),
        .hs_elem_i  (elem_o),
        .accept_o   (accept),
        .load_o     (load),
        .elem_o     (gen_elem),
        .idx_ready_o(idx_ready_o),
        .done_o     (done_o),
        .busy_o     (busy_o),
        .mode_q_o   (mode_q)
    );

    vag_addr #(.ADDR_W(ADDR_W), .WORD_SHIFT(WORD_SHIFT)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .accept_i  (accept),
        .mode_i    (mode_i),
        .base_i    (base_i),
        .stride_i  (stride_i),
        .mode_q_i  (mode_q),
        .load_i    (load),
        .idx_data_i(idx_data_i),
        .addr_o    (gen_addr)
    );

    vag_out #(.ADDR_W(ADDR_W), .ELEM_W(ELEM_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load),
        .addr_i    (gen_addr),
        .elem_i    (gen_elem),
        .ready_i   (addr_ready_i),
        .valid_o   (addr_valid_o),
        .addr_o    (addr_o),
        .elem_o    (elem_o),
        .can_load_o(can_load),
        .hs_o      (hs)
    );

    // edges elapsed since the last accepted start, saturating
    logic [AGE_W-1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)                           age_q <= AGE_W'(STARTUP);
        else if (accept)                   age_q <= '0;
        else if (age_q < AGE_W'(STARTUP))  age_q <= age_q + AGE_W'(1);
    end

    // no beat inside the start-up window
    assert_startup_gap_R6: assert property (@(posedge clk) disable iff (rst)
        (age_q < AGE_W'(STARTUP - 1)) |=> !addr_valid_o);

    // done never coincides with a pending beat
    assert_done_clear_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !addr_valid_o);

    // beats only appear while an access is in progress
    assert_valid_busy_R10: assert property (@(posedge clk) disable iff (rst)
        addr_valid_o |-> busy_o);

endmodule

// File: tb/vec_addr_gen_test.sv
`timescale 1ns/1ps
module vec_addr_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic [31:0] base_i = '0;
    logic [31:0] stride_i = '0;
    logic [6:0]  vlen_i = '0;
    logic        busy_o;
    logic        idx_valid_i = 1'b0;
    logic [31:0] idx_data_i = '0;
    logic        idx_ready_o;
    logic        addr_valid_o;
    logic        addr_ready_i = 1'b0;
    logic [31:0] addr_o;
    logic [5:0]  elem_o;
    logic        done_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [31:0] idxv [64];

    always #5 clk = ~clk;

    vec_addr_gen uut (
        .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
        .base_i(base_i), .stride_i(stride_i), .vlen_i(vlen_i),
        .busy_o(busy_o), .idx_valid_i(idx_valid_i), .idx_data_i(idx_data_i),
        .idx_ready_o(idx_ready_o), .addr_valid_o(addr_valid_o),
        .addr_ready_i(addr_ready_i), .addr_o(addr_o), .elem_o(elem_o),
        .done_o(done_o)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // reference: expected address of element k
    function automatic logic [31:0] ref_addr(input logic [1:0] md, input logic [31:0] b,
                                             input logic [31:0] s, input int k);
        case (md)
            2'd0:    return b + 32'(k * 8);
            2'd1:    return b + 32'(k) * s;
            default: return b + idxv[k];
        endcase
    endfunction

    task automatic run(input logic [1:0] md, input logic [31:0] b, input logic [31:0] s,
                       input logic [6:0] vl, input bit bp, input bit gap, input bit glitch,
                       input string tag);
        int n, m, k, j, done_at;
        bit held;
        logic [31:0] h_addr;
        logic [5:0] h_elem;
        n = (vl > 7'd64) ? 64 : int'(vl);
        k = 0; j = 0; held = 0; h_addr = '0; h_elem = '0;
        done_at = (n == 0) ? 0 : -1;
        @(negedge clk);
        start_i = 1'b1; mode_i = md; base_i = b; stride_i = s; vlen_i = vl;
        @(negedge clk);
        start_i = 1'b0; mode_i = 2'd0; base_i = '0; stride_i = '0; vlen_i = '0;
        m = 0;
        forever begin
            addr_ready_i = bp ? ((m % 3) != 1) : 1'b1;
            idx_valid_i  = (md >= 2'd2) && (j < n) && (gap ? ((m % 4) != 2) : 1'b1);
            idx_data_i   = (j < 64) ? idxv[j] : 32'd0;
            if (glitch && m == 5) begin
                start_i = 1'b1; vlen_i = 7'd1; base_i = 32'hDEAD0000; mode_i = 2'd1;
            end else begin
                start_i = 1'b0;
            end
            #1;
            // R9 done only in its own cycle
            check(done_o == (m == done_at), {tag, " R9 done"}, 32'(done_o), 32'(m == done_at));
            if (m == done_at) begin
                check(busy_o == 1'b0, {tag, " R10 busy clears"}, 32'(busy_o), 0);
                check(addr_valid_o == 1'b0, {tag, " R9 no beat at done"}, 32'(addr_valid_o), 0);
                if (n == 0) check(k == 0, {tag, " R9 zero length issues nothing"}, 32'(k), 0);
                else check(k == n, {tag, " R5 element count"}, 32'(k), 32'(n));
                if (md < 2'd2 && !bp && n > 0)
                    check(done_at == 12 + n, {tag, " R7 gap-free rate"}, 32'(done_at), 32'(12 + n));
                break;
            end
            if (n > 0) check(busy_o == 1'b1, {tag, " R10 busy during access"}, 32'(busy_o), 1);
            if (m < 12)
                check(addr_valid_o == 1'b0, {tag, " R6 start-up quiet"}, 32'(addr_valid_o), 0);
            if (m == 12 && md < 2'd2)
                check(addr_valid_o == 1'b1, {tag, " R6 first beat on time"}, 32'(addr_valid_o), 1);
            if (held) begin
                check(addr_valid_o && addr_o == h_addr && elem_o == h_elem,
                      {tag, " R8 hold"}, addr_o, h_addr);
            end
            held = addr_valid_o && !addr_ready_i;
            h_addr = addr_o; h_elem = elem_o;
            if (md < 2'd2)
                check(idx_ready_o == 1'b0, {tag, " R3 no index take"}, 32'(idx_ready_o), 0);
            if (addr_valid_o && addr_ready_i) begin
                check(elem_o == 6'(k), {tag, " R5 element tag"}, 32'(elem_o), 32'(k));
                check(addr_o == ref_addr(md, b, s, k),
                      {tag, (md == 2'd0) ? " R1" : (md == 2'd1) ? " R2" :
                            (md == 2'd2) ? " R3" : " R4", " address"},
                      addr_o, ref_addr(md, b, s, k));
                k++;
                if (k == n) done_at = m + 1;
            end
            if (idx_valid_i && idx_ready_o) j++;
            if (m > 2000) begin
                check(1'b0, {tag, " R9 run ended"}, 32'(m), 32'(done_at));
                break;
            end
            @(negedge clk);
            m++;
        end
        start_i = 1'b0; idx_valid_i = 1'b0; addr_ready_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 64; i++)
            idxv[i] = (i % 2 == 0) ? 32'(i * 40 + 16) : -32'(i * 24);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(!addr_valid_o && !done_o && !busy_o && !idx_ready_o,
              "R9 reset state", {28'd0, addr_valid_o, done_o, busy_o, idx_ready_o}, 0);
        run(2'd0, 32'h0000_1000, 32'd0,          7'd5,   0, 0, 0, "unit");
        run(2'd1, 32'h0000_2000, 32'hFFFF_FFE8,  7'd7,   1, 0, 0, "negstride");
        run(2'd1, 32'hFFFF_FFF0, 32'h0000_0010,  7'd4,   0, 0, 0, "wrap");
        run(2'd2, 32'h0000_8000, 32'd0,          7'd9,   1, 1, 0, "gather");
        run(2'd3, 32'h0000_8000, 32'd0,          7'd9,   0, 1, 0, "scatter");
        run(2'd0, 32'h0000_4000, 32'd0,          7'd0,   0, 0, 0, "zero");
        run(2'd0, 32'h0001_0000, 32'd0,          7'd100, 0, 0, 0, "cap");
        run(2'd1, 32'h0000_3000, 32'd12,         7'd6,   0, 0, 1, "ignore");
        run(2'd2, 32'h0000_0100, 32'd0,          7'd64,  1, 0, 0, "gatherfull");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule